// File: doc/BRIEF.md
# Multiplexer-Based Logic Tile

This block is a fine-grain logic cell made only of 2:1 multiplexers. Two front multiplexers each pick one of a pair of data inputs under their own select line. A third multiplexer then picks between the two front results. Its select is the OR of two further select inputs. Any Boolean function comes from wiring the eight cell inputs to live signals or to the constants 0 and 1. No lookup table and no product-term array is involved.

The tile exposes three views of the same cell. The first is the bare cell, with all eight inputs driven directly. The second is a configured cell: a 24-bit tie-off word picks, for each cell input, a constant, one of two nets, or the complement of a net. Each complement comes from an extra cell wired as an inverter. The third is an edge-triggered flip-flop. It is built from two level-sensitive stages in series, and a front cell forces the data to 0 during reset.

Top module: `mux_logic_tile`

## Requirements
- R1: When both final-select inputs (cell_in[6] and cell_in[7]) are 0, cell_y equals cell_in[1] if cell_in[2] is 1, and cell_in[0] otherwise.
- R2: When either final-select input is 1, cell_y equals cell_in[4] if cell_in[5] is 1, and cell_in[3] otherwise.
- R3: For all 256 values of cell_in, cell_y matches the reference function of R1 and R2. The bit order of cell_in is {s1, s0, sb, b1, b0, sa, a1, a0} from bit 7 down to bit 0.
- R4: Each 3-bit source code in cfg_sel drives its cell input as follows: 0 gives constant 0, 1 gives constant 1, 2 gives net_p, 3 gives net_q, 4 gives NOT net_p and 5 gives NOT net_q. Codes 6 and 7 give constant 0.
- R5: In cfg_sel, field i (bits 3i+2 down to 3i) drives cell input i, in the same order as cell_in in R3.
- R6: A single multiplexer forms AND when its data inputs are {0, q} and its select is p. It forms OR when its data inputs are {q, 1} and its select is p.
- R7: All 16 two-input functions of (net_p, net_q) are produced by the same pattern. The final select is net_p. The front selects are net_q. The four data inputs are constants taken from the function's truth table.
- R8: A cell whose data inputs are 1 and 0, with the signal on the select, acts as an inverter. NAND is produced through the complemented sources.
- R9: q_out takes the value that d_in had at each rising clk edge and holds it until the next edge.
- R10: Changes on d_in between rising edges, while clk is high or while it is low, do not reach q_out.
- R11: Reset is synchronous and active-high. rst high at a rising edge clears q_out to 0. rst raised between edges leaves q_out unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the flip-flop view |
| rst | input | 1 | Synchronous active-high reset of the flip-flop view |
| cell_in | input | 8 | Direct inputs of the bare cell, {s1,s0,sb,b1,b0,sa,a1,a0} |
| cell_y | output | 1 | Output of the bare cell |
| cfg_sel | input | 24 | Tie-off word, eight 3-bit source codes |
| net_p | input | 1 | First signal net of the configured cell |
| net_q | input | 1 | Second signal net of the configured cell |
| cfg_y | output | 1 | Output of the configured cell |
| d_in | input | 1 | Data input of the flip-flop view |
| q_out | output | 1 | Output of the flip-flop view |

## Verification
The hardest case to reach is the flip-flop's behaviour between edges. Data that moves while the front stage is open must stay inside the flop. Data that moves while the back stage is open must not be picked up at all. The bench changes d_in in the middle of the high phase and again in the low phase, reads q_out before the next rising edge, and only then lets the edge move the value through. Reset is handled the same way: it is raised in the middle of a cycle while q_out holds 1, to show that clearing waits for the edge.

// File: rtl/muxcell_pkg.sv
package muxcell_pkg;

    localparam int unsigned PIN_COUNT = 8;
    localparam int unsigned SRC_W     = 3;
    localparam int unsigned CFG_W     = PIN_COUNT * SRC_W;

    // Source codes for one cell input in the tie-off word.
    typedef enum logic [SRC_W-1:0] {
        SRC_ZERO = 3'd0,
        SRC_ONE  = 3'd1,
        SRC_P    = 3'd2,
        SRC_Q    = 3'd3,
        SRC_PN   = 3'd4,
        SRC_QN   = 3'd5,
        SRC_RSV6 = 3'd6,
        SRC_RSV7 = 3'd7
    } src_e;

    // The eight cell inputs. The first member is the most significant bit.
    typedef struct packed {
        logic s1;
        logic s0;
        logic sb;
        logic b1;
        logic b0;
        logic sa;
        logic a1;
        logic a0;
    } cell_pins_t;

    // Nets that a tie-off code can draw from.
    typedef struct packed {
        logic p;
        logic q;
        logic pn;
        logic qn;
    } net_set_t;

    function automatic logic pick_src(input src_e code, input net_set_t nets);
        logic v;
        case (code)
            SRC_ZERO: v = 1'b0;
            SRC_ONE:  v = 1'b1;
            SRC_P:    v = nets.p;
            SRC_Q:    v = nets.q;
            SRC_PN:   v = nets.pn;
            SRC_QN:   v = nets.qn;
            default:  v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mux2_prim.sv
module mux2_prim (
    input  logic d0,
    input  logic d1,
    input  logic sel,
    output logic y
);
    assign y = sel ? d1 : d0;
endmodule

// File: rtl/mux_logic_module.sv
module mux_logic_module
    import muxcell_pkg::*;
(
    input  cell_pins_t pins,
    output logic       y
);
    logic front_a;
    logic front_b;
    logic final_sel;

    mux2_prim u_front_a (.d0(pins.a0), .d1(pins.a1), .sel(pins.sa), .y(front_a));
    mux2_prim u_front_b (.d0(pins.b0), .d1(pins.b1), .sel(pins.sb), .y(front_b));

    // The final select is the OR gate on the two extra select inputs.
    assign final_sel = pins.s0 | pins.s1;

    mux2_prim u_final (.d0(front_a), .d1(front_b), .sel(final_sel), .y(y));
endmodule

// File: rtl/mux_tieoff_cell.sv
module mux_tieoff_cell
    import muxcell_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             p,
    input  logic             q,
    output logic             y
);
    cell_pins_t inv_p_pins;
    cell_pins_t inv_q_pins;
    logic       p_n;
    logic       q_n;
    net_set_t   nets;
    logic [PIN_COUNT-1:0] pin_bits;
    cell_pins_t main_pins;

    // Inverter cells: data inputs 1 and 0, with the net on the select.
    always_comb begin
        inv_p_pins    = '0;
        inv_p_pins.a0 = 1'b1;
        inv_p_pins.a1 = 1'b0;
        inv_p_pins.sa = p;
        inv_q_pins    = '0;
        inv_q_pins.a0 = 1'b1;
        inv_q_pins.a1 = 1'b0;
        inv_q_pins.sa = q;
    end

    mux_logic_module u_inv_p (.pins(inv_p_pins), .y(p_n));
    mux_logic_module u_inv_q (.pins(inv_q_pins), .y(q_n));

    assign nets = '{p: p, q: q, pn: p_n, qn: q_n};

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        assign pin_bits[i] = pick_src(src_e'(cfg[i*SRC_W +: SRC_W]), nets);
    end

    assign main_pins = cell_pins_t'(pin_bits);

    mux_logic_module u_main (.pins(main_pins), .y(y));
endmodule

// File: rtl/mux_latch.sv
module mux_latch #(
    parameter bit OPEN_WHEN_HIGH = 1'b1
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    if (OPEN_WHEN_HIGH) begin : g_high
        always_latch begin
            if (clk) q <= d;
        end
    end else begin : g_low
        always_latch begin
            if (!clk) q <= d;
        end
    end
endmodule

// File: rtl/mux_edge_flop.sv
module mux_edge_flop
    import muxcell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    cell_pins_t clr_pins;
    logic       d_gated;
    logic       master_q;

    // Front cell: passes d, or the constant 0 while rst is high.
    always_comb begin
        clr_pins    = '0;
        clr_pins.a0 = d;
        clr_pins.a1 = 1'b0;
        clr_pins.sa = rst;
    end

    mux_logic_module u_clr (.pins(clr_pins), .y(d_gated));

    mux_latch #(.OPEN_WHEN_HIGH(1'b0)) u_master (.clk(clk), .d(d_gated),  .q(master_q));
    mux_latch #(.OPEN_WHEN_HIGH(1'b1)) u_slave  (.clk(clk), .d(master_q), .q(q));
endmodule

// File: rtl/mux_logic_tile.sv
module mux_logic_tile
    import muxcell_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cell_in,
    output logic             cell_y,
    input  logic [CFG_W-1:0] cfg_sel,
    input  logic             net_p,
    input  logic             net_q,
    output logic             cfg_y,
    input  logic             d_in,
    output logic             q_out
);
    cell_pins_t raw_pins;
    assign raw_pins = cell_pins_t'(cell_in);

    mux_logic_module u_bare (.pins(raw_pins), .y(cell_y));

    mux_tieoff_cell u_cfg (.cfg(cfg_sel), .p(net_p), .q(net_q), .y(cfg_y));

    mux_edge_flop u_flop (.clk(clk), .rst(rst), .d(d_in), .q(q_out));

    // R1
    front_a_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!cell_in[6] && !cell_in[7]) |-> cell_y == (cell_in[2] ? cell_in[1] : cell_in[0]));

    // R2
    front_b_route_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_in[6] || cell_in[7]) |-> cell_y == (cell_in[5] ? cell_in[4] : cell_in[3]));

    // R9
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> q_out == $past(d_in));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> q_out == 1'b0);
endmodule

// File: tb/tb_mux_logic_tile.sv
module tb_mux_logic_tile;
    import muxcell_pkg::*;

    logic             clk;
    logic             rst;
    logic [7:0]       cell_in;
    logic             cell_y;
    logic [CFG_W-1:0] cfg_sel;
    logic             net_p;
    logic             net_q;
    logic             cfg_y;
    logic             d_in;
    logic             q_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    mux_logic_tile dut (
        .clk(clk), .rst(rst), .cell_in(cell_in), .cell_y(cell_y),
        .cfg_sel(cfg_sel), .net_p(net_p), .net_q(net_q), .cfg_y(cfg_y),
        .d_in(d_in), .q_out(q_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    localparam int Z = 0, O = 1, P = 2, Q = 3, PN = 4, QN = 5;

    // Build a tie-off word, arguments in cell input order a0..s1.
    function automatic logic [CFG_W-1:0] mk(input int a0, input int a1, input int sa,
                                            input int b0, input int b1, input int sb,
                                            input int s0, input int s1);
        logic [CFG_W-1:0] c;
        c = '0;
        c[0*SRC_W +: SRC_W] = a0[SRC_W-1:0];
        c[1*SRC_W +: SRC_W] = a1[SRC_W-1:0];
        c[2*SRC_W +: SRC_W] = sa[SRC_W-1:0];
        c[3*SRC_W +: SRC_W] = b0[SRC_W-1:0];
        c[4*SRC_W +: SRC_W] = b1[SRC_W-1:0];
        c[5*SRC_W +: SRC_W] = sb[SRC_W-1:0];
        c[6*SRC_W +: SRC_W] = s0[SRC_W-1:0];
        c[7*SRC_W +: SRC_W] = s1[SRC_W-1:0];
        return c;
    endfunction

    // Directed tie-off vectors: {cfg, truth table}, truth bit index {p,q}.
    localparam int NVEC = 10;
    localparam logic [CFG_W+3:0] VEC [NVEC] = '{
        {mk(Z, Q, P, Z, Z, Z, Z, Z), 4'h8},   // R6 AND
        {mk(Q, O, P, Z, Z, Z, Z, Z), 4'hE},   // R6 OR
        {mk(O, Z, P, Z, Z, Z, Z, Z), 4'h3},   // R8 inverter on p
        {mk(QN, O, PN, Z, Z, Z, Z, Z), 4'h7}, // R8 NAND via complements
        {mk(O, Z, Z, Z, Z, Z, Z, Z), 4'hF},   // R4 constant one
        {mk(Z, Z, Z, Q, Q, Z, Z, O), 4'hA},   // R4 q through second front mux
        {mk(6, O, Z, Z, Z, Z, Z, Z), 4'h0},   // R4 reserved code 6
        {mk(7, O, Z, Z, Z, Z, Z, Z), 4'h0},   // R4 reserved code 7
        {mk(Z, Z, Z, O, Z, Z, QN, Z), 4'h5},  // R5 field order, s0
        {mk(Q, Z, Z, Z, PN, O, Z, P), 4'h2}   // R5 field order, b1 sb s1
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [CFG_W-1:0] shannon_cfg(input logic [3:0] tt);
        return mk(tt[0] ? O : Z, tt[1] ? O : Z, Q, tt[2] ? O : Z, tt[3] ? O : Z, Q, P, Z);
    endfunction

    initial begin
        rst = 1'b1; d_in = 1'b1; cell_in = '0; cfg_sel = '0; net_p = 0; net_q = 0;

        // R11: a reset held across edges clears q_out, even with d_in at 1.
        repeat (2) @(posedge clk);
        #1 chk("R11 reset state", q_out, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R3: full sweep of the bare cell. R1 and R2 name the active route.
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            logic exp;
            @(negedge clk);
            b = v[7:0];
            cell_in = b;
            #1;
            exp = (b[6] | b[7]) ? (b[5] ? b[4] : b[3]) : (b[2] ? b[1] : b[0]);
            chk((b[6] | b[7]) ? "R2/R3 route b" : "R1/R3 route a", cell_y, exp);
        end

        // Directed tie-off table, covering R4, R5, R6 and R8.
        for (int e = 0; e < NVEC; e++) begin
            for (int pq = 0; pq < 4; pq++) begin
                cfg_sel = VEC[e][CFG_W+3:4];
                net_p = pq[1];
                net_q = pq[0];
                #1 chk($sformatf("R4/R5/R6/R8 vector %0d pq %0d", e, pq),
                       cfg_y, VEC[e][pq]);
            end
        end

        // R7: all 16 two-input functions from one pattern.
        for (int f = 0; f < 16; f++) begin
            for (int pq = 0; pq < 4; pq++) begin
                logic [3:0] tt;
                tt = f[3:0];
                cfg_sel = shannon_cfg(tt);
                net_p = pq[1];
                net_q = pq[0];
                #1 chk($sformatf("R7 function %0d pq %0d", f, pq), cfg_y, tt[pq]);
            end
        end

        // R9: capture at the rising edge.
        for (int k = 0; k < 6; k++) begin
            logic bit_v;
            bit_v = ((6'b101101 >> k) & 6'd1) != 0;
            @(negedge clk); d_in = bit_v;
            @(posedge clk); #1 chk("R9 capture", q_out, bit_v);
        end

        // R10: d_in moves while clk is high, then while it is low.
        @(negedge clk); d_in = 1'b1;
        @(posedge clk); #1 chk("R10 setup", q_out, 1'b1);
        #1 d_in = 1'b0;
        #2 chk("R10 change while high", q_out, 1'b1);
        @(negedge clk); #1 d_in = 1'b1; #1 d_in = 1'b0;
        #1 chk("R10 change while low", q_out, 1'b1);
        @(posedge clk); #1 chk("R10 edge after changes", q_out, 1'b0);

        // R11: reset raised between edges waits for the next edge.
        @(negedge clk); d_in = 1'b1;
        @(posedge clk); #1 chk("R11 pre-reset value", q_out, 1'b1);
        @(negedge clk); rst = 1'b1;
        #2 chk("R11 no clear before edge", q_out, 1'b1);
        @(posedge clk); #1 chk("R11 clear at edge", q_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1 chk("R11 resume after reset", q_out, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule